// File: doc/BRIEF.md
# Comparator Interrupt Mode Controller

This block turns the single digital output of an analog comparator (1 when the positive input is above the negative input, 0 otherwise) into a sticky status flag and an interrupt request. A 3-bit trigger mode selects what counts as an event. The options are a low or high level, a rising or falling edge, or a toggle in either direction. Each edge and toggle choice also has a debounced form that waits for the new level to stay put over debounce ticks before the event is accepted.

The raw comparator bit is brought into the clock domain by a synchroniser first, and detection runs on the synchronised copy. An external timer supplies a one-cycle debounce tick. Software clears the flag with a one-cycle strobe. Turning the enable off stops new events. Turning it on again discards any edge history, so the act of enabling cannot trigger an event.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: The raw comparator bit passes through a two-flop synchroniser. A change driven before clock edge k can set the flag at edge k+2 at the earliest, and not before.
- R2: While the enable is low, the flag is never set. A flag that is already set keeps its value until it is cleared.
- R3: Level modes: trig_mode 000 sets the flag on every clock while the synchronised input is 0, and 111 does so while it is 1. The flag is therefore set again one cycle after a clear if the level still holds.
- R4: Plain edge modes: 001 sets the flag on a 0-to-1 change of the synchronised input, and 100 sets it on a 1-to-0 change. A change in the other direction has no effect.
- R5: Plain toggle mode 101 sets the flag on a change in either direction. A constant input never sets it.
- R6: Debounced modes are 011 (rising), 110 (falling) and 010 (either direction). A detected change is held pending, and the flag is set at the second debounce tick after detection if the input has not changed in between. A change before that tick cancels the pending event.
- R7: flag_clr clears the flag on the next clock edge. It wins over an event that would set the flag in the same cycle.
- R8: Enabling the comparator logic discards edge history. A level that changed while the block was disabled produces no event after enabling.
- R9: irq is a register that follows the flag while the block is enabled and is 0 while it is disabled.
- R10: After a synchronous reset, cmp_flag and irq are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Raw comparator result, 1 when positive input exceeds negative input |
| cmp_en | input | 1 | Enables event detection |
| trig_mode | input | 3 | Trigger mode selection |
| db_tick | input | 1 | One-cycle debounce interval tick |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cmp_flag | output | 1 | Sticky comparator event flag |
| irq | output | 1 | Interrupt request |

## Verification
A vector table runs each of the eight modes with chosen start and end levels: the matching transition, the opposite transition, or no transition. This distinguishes rising from falling, plain from toggle, and level from edge detection, and it shows whether the debounced forms complete after two ticks. Directed sequences cover the rest. A bounce during the debounce window must cancel the event, and a single tick must not be enough to set the flag. They also check the exact synchroniser latency, a clear that meets an event in the same cycle, a level flag coming back after a clear, a change made while disabled, and the irq gating as the enable switches.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  typedef struct packed {
    logic is_level;
    logic lvl;
    logic want_rise;
    logic want_fall;
    logic db;
  } trig_dec_t;

  function automatic trig_dec_t trig_decode(input logic [2:0] m);
    trig_dec_t d;
    d = '0;
    case (m)
      3'b000: begin d.is_level = 1'b1; d.lvl = 1'b0; end
      3'b111: begin d.is_level = 1'b1; d.lvl = 1'b1; end
      3'b001: d.want_rise = 1'b1;
      3'b100: d.want_fall = 1'b1;
      3'b101: begin d.want_rise = 1'b1; d.want_fall = 1'b1; end
      3'b011: begin d.want_rise = 1'b1; d.db = 1'b1; end
      3'b110: begin d.want_fall = 1'b1; d.db = 1'b1; end
      default: begin d.want_rise = 1'b1; d.want_fall = 1'b1; d.db = 1'b1; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_trigger.sv
module cmp_trigger
  import cmp_irq_pkg::*;
#(
  parameter int DB_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       s,
  input  logic [2:0] mode,
  input  logic       tick,
  output logic       ev
);
  localparam int CNT_W = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_TICKS - 1);

  trig_dec_t  dec;
  logic       s_q, en_q, pend_q, cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic       chg, hit, level_hit, load, cancel, db_ev;

  assign dec       = trig_decode(mode);
  assign chg       = en && en_q && (s != s_q);
  assign hit       = chg && ((s && dec.want_rise) || (!s && dec.want_fall));
  assign level_hit = en && dec.is_level && (s == dec.lvl);
  assign load      = dec.db && hit;
  assign cancel    = pend_q && (s != cand_q);
  assign db_ev     = en && dec.db && pend_q && !cancel && tick && (cnt_q == LAST);
  assign ev        = level_hit || (hit && !dec.db) || db_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q  <= 1'b0;
      en_q <= 1'b0;
    end else begin
      s_q  <= s;
      en_q <= en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend_q <= 1'b0;
      cand_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      cand_q <= s;
      cnt_q  <= '0;
    end else if (cancel || !dec.db) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q && tick) begin
      if (cnt_q == LAST) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6: a debounced event only completes on a tick with a pending candidate
  p_db_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (dec.db && ev) |-> (tick && pend_q));

  // R8: the first enabled cycle never yields an edge event
  p_no_edge_on_enable_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !en_q && !dec.is_level) |-> !ev);

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DB_TICKS    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_raw,
  input  logic       cmp_en,
  input  logic [2:0] trig_mode,
  input  logic       db_tick,
  input  logic       flag_clr,
  output logic       cmp_flag,
  output logic       irq
);
  logic s, ev, flag_n;

  cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(cmp_raw), .q(s)
  );

  cmp_trigger #(.DB_TICKS(DB_TICKS)) i_trig (
    .clk(clk), .rst(rst), .en(cmp_en), .s(s), .mode(trig_mode),
    .tick(db_tick), .ev(ev)
  );

  assign flag_n = flag_clr ? 1'b0 : (cmp_flag | ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      cmp_flag <= flag_n;
      irq      <= flag_n & cmp_en;
    end
  end

  // R2: disabled logic never raises the flag
  p_no_set_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en && !cmp_flag) |=> !cmp_flag);

  // R7: clear strobe wins
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !cmp_flag);

  // R9: no request while disabled
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> !irq);

  // R3: a held level re-sets the flag
  p_level_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !flag_clr && trig_decode(trig_mode).is_level &&
     s == trig_decode(trig_mode).lvl) |=> cmp_flag);

endmodule

// File: tb/test_cmp_irq_ctrl.sv
module test_cmp_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 17;
  // {mode[2:0], start level, end level, expected flag}
  localparam logic [5:0] VEC [NVEC] = '{
    {3'b000, 1'b1, 1'b1, 1'b0}, {3'b000, 1'b1, 1'b0, 1'b1},
    {3'b111, 1'b0, 1'b0, 1'b0}, {3'b111, 1'b0, 1'b1, 1'b1},
    {3'b001, 1'b0, 1'b1, 1'b1}, {3'b001, 1'b1, 1'b0, 1'b0},
    {3'b100, 1'b1, 1'b0, 1'b1}, {3'b100, 1'b0, 1'b1, 1'b0},
    {3'b101, 1'b0, 1'b1, 1'b1}, {3'b101, 1'b1, 1'b0, 1'b1},
    {3'b101, 1'b1, 1'b1, 1'b0}, {3'b011, 1'b0, 1'b1, 1'b1},
    {3'b011, 1'b1, 1'b0, 1'b0}, {3'b110, 1'b1, 1'b0, 1'b1},
    {3'b110, 1'b0, 1'b1, 1'b0}, {3'b010, 1'b1, 1'b0, 1'b1},
    {3'b010, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, cmp_raw = 1'b0, cmp_en = 1'b0;
  logic [2:0] trig_mode = 3'b000;
  logic db_tick = 1'b0, flag_clr = 1'b0;
  logic cmp_flag, irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_irq_ctrl i_cmp_irq_ctrl (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .cmp_en(cmp_en),
    .trig_mode(trig_mode), .db_tick(db_tick), .flag_clr(flag_clr),
    .cmp_flag(cmp_flag), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    db_tick = 1'b1; @(negedge clk); db_tick = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  // disable, settle at a level, enable in a mode, clear
  task automatic prep(input logic [2:0] m, input logic lvl);
    cmp_en = 1'b0; cmp_raw = lvl; pulse_clr(); clks(3);
    cmp_en = 1'b1; trig_mode = m; clks(1);
    pulse_clr();
  endtask

  initial begin
    clks(3);
    rst = 1'b0;
    clks(1);
    check("R10 flag", cmp_flag, 1'b0);
    check("R10 irq", irq, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      prep(VEC[i][5:3], VEC[i][2]);
      cmp_raw = VEC[i][1];
      clks(3);
      pulse_tick(); pulse_tick();
      check($sformatf("R3/R4/R5/R6 vec%0d flag", i), cmp_flag, VEC[i][0]);
      check($sformatf("R9 vec%0d irq", i), irq, VEC[i][0]);
    end

    // R1: exact synchroniser latency in toggle mode
    prep(3'b101, 1'b0);
    cmp_raw = 1'b1; clks(2);
    check("R1 not yet", cmp_flag, 1'b0);
    clks(1);
    check("R1 set", cmp_flag, 1'b1);

    // R2: change while disabled sets nothing
    prep(3'b001, 1'b0);
    cmp_en = 1'b0; cmp_raw = 1'b1; clks(5);
    check("R2 flag", cmp_flag, 1'b0);
    check("R2 irq", irq, 1'b0);
    // R8: enabling after the change yields no event
    cmp_en = 1'b1; clks(5);
    check("R8 flag", cmp_flag, 1'b0);

    // R6: one tick is not enough, a bounce cancels
    prep(3'b011, 1'b0);
    cmp_raw = 1'b1; clks(3);
    pulse_tick();
    check("R6 one tick", cmp_flag, 1'b0);
    cmp_raw = 1'b0; clks(3);
    cmp_raw = 1'b1; clks(1);
    pulse_tick(); pulse_tick();
    check("R6 bounce cancels", cmp_flag, 1'b0);

    // R7: clear meeting an edge event in the same cycle
    prep(3'b101, 1'b0);
    cmp_raw = 1'b1; clks(2);
    pulse_clr();
    check("R7 clear wins", cmp_flag, 1'b0);
    clks(3);
    check("R7 event consumed", cmp_flag, 1'b0);

    // R3: level flag returns one cycle after a clear
    prep(3'b111, 1'b1);
    clks(1);
    pulse_clr();
    check("R3 cleared", cmp_flag, 1'b0);
    clks(1);
    check("R3 re-set", cmp_flag, 1'b1);

    // R9: irq follows enable while flag stays
    cmp_en = 1'b0; trig_mode = 3'b001; clks(1);
    check("R9 irq off", irq, 1'b0);
    check("R2 flag kept", cmp_flag, 1'b1);
    cmp_en = 1'b1; clks(1);
    check("R9 irq on", irq, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule